// File: doc/BRIEF.md
# Configuration Address/Data Access Bridge

This block sits on the host side of a configuration fabric. A processor reaches it through two registers. The first is a 32-bit target-address latch. The second is a data window that accepts byte, halfword and word accesses. Writing the latch selects a bus, a device, a function and a register offset. Each later access to the data window becomes one configuration read or write on a downstream request channel. That request carries decoded fields, byte enables and lane-aligned write data.

The downstream side answers each request with read data and a flag that says whether any target claimed the access. If no target claims a read, the bridge builds the result itself: all ones, sized to the access. If no target claims a write, the write completes and leaves nothing behind. A mode input selects whether the latch contents are byte-reversed as they pass through the processor port, which supports processors of either byte order.

Top module: `cfg_bridge`

## Requirements
- R1: After a synchronous active-high reset, a read of the address latch (`cpu_sel`=0) returns 0x00000000.
- R2: With `swap_mode`=0, a write to the address latch stores all 32 bits, and a later read returns exactly the value written.
- R3: With `swap_mode`=1, the latch value is byte-reversed on write and again on read. A read in swap mode returns the written value, a read in plain mode returns it reversed, and decoding uses the stored (reversed) value.
- R4: Every data-window request takes its bus number from latch bits 23:16, its device number from bits 15:11 and its function number from bits 10:8. Bits 31:24 have no effect on the request.
- R5: The request offset is 8 bits wide. It is latch bits 7:2 joined with (latch bits 1:0 OR `cpu_lane`), so it always lies inside the 256-byte configuration space.
- R6: `cpu_size` encodes the access width: 00 is byte, 01 is halfword, 10 is word. Let b be offset bits 1:0. A byte access enables lane b. A halfword access enables lanes {b[1],0} and {b[1],1}. A word access enables all four lanes. Write data, right-justified on `cpu_wdata`, is shifted up to start at the lowest enabled lane.
- R7: When a target claims a read, `cpu_rdata` is the response word shifted down by the lowest enabled lane and zero-extended above the access width.
- R8: When no target claims a read, `cpu_rdata` is 0x000000FF for a byte access, 0x0000FFFF for a halfword access and 0xFFFFFFFF for a word access.
- R9: The unused size code 11 behaves as a word access. It gives byte enables 1111 and, when no target claims the read, returns 0xFFFFFFFF.
- R10: A data-window write that no target claims completes with `cpu_ready` and changes neither the address latch nor any claimed target's contents.
- R11: Once `dn_valid` rises, it stays high with stable fields until `dn_ready`. `cpu_ready` stays low from the start of a data access until its response has been taken. Each data access makes exactly one downstream request.
- R12: An address-latch access completes in the cycle it is presented (`cpu_ready` high combinationally) and makes no downstream request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| swap_mode | input | 1 | 1 = byte-reverse the address latch at the processor port |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_sel | input | 1 | 0 = address latch, 1 = data window |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | Data-window access width code |
| cpu_lane | input | 2 | Byte address within the data window |
| cpu_wdata | input | 32 | Write data, right-justified |
| cpu_ready | output | 1 | Access completes at the clock edge where this and `cpu_req` are high |
| cpu_rdata | output | 32 | Read data, valid while `cpu_ready` is high |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request accepted |
| dn_bus | output | 8 | Target bus number |
| dn_dev | output | 5 | Target device number |
| dn_fn | output | 3 | Target function number |
| dn_off | output | 8 | Register offset in configuration space |
| dn_be | output | 4 | Byte enables |
| dn_wdata | output | 32 | Lane-aligned write data |
| dn_we | output | 1 | 1 = configuration write |
| rsp_valid | input | 1 | Downstream response valid |
| rsp_data | input | 32 | Response word |
| rsp_present | input | 1 | 1 = a target claimed the access |

## Verification
The hardest case to reach is a latch offset with low bits already set, combined with a nonzero window lane and a narrow access. Only that case shows the OR merge of the offset together with the lane shift in both directions. The stimulus writes latch offsets ending in 0 and in 0xFC, then sweeps byte and halfword accesses across lanes. The reference responder inserts varying accept and response delays, so the hold and stall behaviour is exercised with gaps of several lengths. Absent targets come from chosen bus, device and function values, and the responder returns a garbage word on them so that any leak of response data into the all-ones fill is visible.

// File: rtl/cfgbr_pkg.sv
package cfgbr_pkg;

    localparam int WORD_W  = 32;
    localparam int LANES   = WORD_W / 8;
    localparam int LANE_AW = $clog2(LANES);
    localparam int BUS_W   = 8;
    localparam int DEV_W   = 5;
    localparam int FN_W    = 3;
    localparam int OFF_W   = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_ODD  = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_DONE
    } seq_e;

    typedef struct packed {
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
        logic [FN_W-1:0]  fn;
        logic [OFF_W-1:0] off;
    } tgt_t;

    function automatic logic [WORD_W-1:0] bswap32(input logic [WORD_W-1:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [LANE_AW-1:0] lane_shift(input acc_size_e s,
                                                      input logic [LANE_AW-1:0] a);
        case (s)
            SZ_BYTE: return a;
            SZ_HALF: return {a[1], 1'b0};
            default: return '0;
        endcase
    endfunction

    function automatic logic [LANES-1:0] size_be(input acc_size_e s,
                                                 input logic [LANE_AW-1:0] a);
        logic [LANES-1:0] base;
        case (s)
            SZ_BYTE: base = 4'b0001;
            SZ_HALF: base = 4'b0011;
            default: base = 4'b1111;
        endcase
        return base << lane_shift(s, a);
    endfunction

    function automatic logic [WORD_W-1:0] size_mask(input acc_size_e s);
        case (s)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cfgbr_addr_reg.sv
module cfgbr_addr_reg
    import cfgbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              swap,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output tgt_t              tgt
);

    logic [WORD_W-1:0] stored;
    logic [7:0]        unused_hi;

    always_ff @(posedge clk) begin
        if (rst)        stored <= '0;
        else if (wr_en) stored <= swap ? bswap32(wdata) : wdata;
    end

    assign rdata     = swap ? bswap32(stored) : stored;
    assign tgt       = tgt_t'(stored[BUS_W+DEV_W+FN_W+OFF_W-1:0]);
    assign unused_hi = stored[WORD_W-1:BUS_W+DEV_W+FN_W+OFF_W];

    // R2 / R10: the latch only moves on an explicit latch write
    assert_latch_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(stored));

endmodule

// File: rtl/cfgbr_lane.sv
module cfgbr_lane
    import cfgbr_pkg::*;
(
    input  acc_size_e          size,
    input  logic [LANE_AW-1:0] lane,
    input  logic [OFF_W-1:0]   tgt_off,
    input  logic [WORD_W-1:0]  cpu_wdata,
    input  logic [WORD_W-1:0]  rsp_data,
    input  logic               rsp_present,
    output logic [OFF_W-1:0]   off,
    output logic [LANES-1:0]   be,
    output logic [WORD_W-1:0]  dn_wdata,
    output logic [WORD_W-1:0]  rd_word
);

    logic [LANE_AW-1:0] sh;
    logic [WORD_W-1:0]  mask;

    always_comb begin
        off      = {tgt_off[OFF_W-1:LANE_AW], tgt_off[LANE_AW-1:0] | lane};
        sh       = lane_shift(size, off[LANE_AW-1:0]);
        be       = size_be(size, off[LANE_AW-1:0]);
        mask     = size_mask(size);
        dn_wdata = cpu_wdata << {sh, 3'b000};
        rd_word  = rsp_present ? ((rsp_data >> {sh, 3'b000}) & mask) : mask;
    end

endmodule

// File: rtl/cfgbr_seq.sv
module cfgbr_seq
    import cfgbr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cpu_req,
    input  logic cpu_sel,
    input  logic cpu_we,
    input  logic dn_ready,
    input  logic rsp_valid,
    output logic addr_wr,
    output logic cpu_ready,
    output logic dn_valid,
    output logic cap
);

    seq_e st, st_nx;

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nx;
    end

    always_comb begin
        st_nx     = st;
        addr_wr   = 1'b0;
        cpu_ready = 1'b0;
        dn_valid  = 1'b0;
        cap       = 1'b0;
        case (st)
            ST_IDLE: begin
                if (cpu_req && !cpu_sel) begin
                    cpu_ready = 1'b1;
                    addr_wr   = cpu_we;
                end else if (cpu_req) begin
                    st_nx = ST_REQ;
                end
            end
            ST_REQ: begin
                dn_valid = 1'b1;
                if (dn_ready) st_nx = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    cap   = 1'b1;
                    st_nx = ST_DONE;
                end
            end
            default: begin
                cpu_ready = 1'b1;
                st_nx     = ST_IDLE;
            end
        endcase
    end

    // R11: a response is only taken after its request was accepted
    assert_cap_after_req_R11: assert property (@(posedge clk) disable iff (rst)
        cap |-> !dn_valid && !cpu_ready);

endmodule

// File: rtl/cfg_bridge.sv
module cfg_bridge
    import cfgbr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        swap_mode,
    input  logic        cpu_req,
    input  logic        cpu_sel,
    input  logic        cpu_we,
    input  logic [1:0]  cpu_size,
    input  logic [1:0]  cpu_lane,
    input  logic [31:0] cpu_wdata,
    output logic        cpu_ready,
    output logic [31:0] cpu_rdata,
    output logic        dn_valid,
    input  logic        dn_ready,
    output logic [7:0]  dn_bus,
    output logic [4:0]  dn_dev,
    output logic [2:0]  dn_fn,
    output logic [7:0]  dn_off,
    output logic [3:0]  dn_be,
    output logic [31:0] dn_wdata,
    output logic        dn_we,
    input  logic        rsp_valid,
    input  logic [31:0] rsp_data,
    input  logic        rsp_present
);

    acc_size_e         size;
    tgt_t              tgt;
    logic              addr_wr, cap;
    logic [WORD_W-1:0] addr_rdata, rd_word, data_q;

    assign size = acc_size_e'(cpu_size);

    cfgbr_addr_reg u_addr (
        .clk   (clk),
        .rst   (rst),
        .swap  (swap_mode),
        .wr_en (addr_wr),
        .wdata (cpu_wdata),
        .rdata (addr_rdata),
        .tgt   (tgt)
    );

    cfgbr_lane u_lane (
        .size        (size),
        .lane        (cpu_lane),
        .tgt_off     (tgt.off),
        .cpu_wdata   (cpu_wdata),
        .rsp_data    (rsp_data),
        .rsp_present (rsp_present),
        .off         (dn_off),
        .be          (dn_be),
        .dn_wdata    (dn_wdata),
        .rd_word     (rd_word)
    );

    cfgbr_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .cpu_sel   (cpu_sel),
        .cpu_we    (cpu_we),
        .dn_ready  (dn_ready),
        .rsp_valid (rsp_valid),
        .addr_wr   (addr_wr),
        .cpu_ready (cpu_ready),
        .dn_valid  (dn_valid),
        .cap       (cap)
    );

    always_ff @(posedge clk) begin
        if (rst)      data_q <= '0;
        else if (cap) data_q <= cpu_we ? '0 : rd_word;
    end

    assign dn_bus    = tgt.bus;
    assign dn_dev    = tgt.dev;
    assign dn_fn     = tgt.fn;
    assign dn_we     = cpu_we;
    assign cpu_rdata = cpu_sel ? data_q : addr_rdata;

    // R11: request is held with stable fields until accepted
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
        dn_valid && !dn_ready |=> dn_valid &&
        $stable({dn_bus, dn_dev, dn_fn, dn_off, dn_be, dn_wdata, dn_we}));

    // R11: processor never completes while a request is outstanding
    assert_no_early_ready_R11: assert property (@(posedge clk) disable iff (rst)
        dn_valid |-> !cpu_ready);

    // R12: latch accesses never reach downstream
    assert_latch_local_R12: assert property (@(posedge clk) disable iff (rst)
        cpu_req && !cpu_sel && cpu_ready |-> !dn_valid);

    // R6: a byte access enables exactly one lane
    assert_byte_one_lane_R6: assert property (@(posedge clk) disable iff (rst)
        dn_valid && size == SZ_BYTE |-> $countones(dn_be) == 1);

    // R8: unclaimed read completes with all ones over the access width
    assert_absent_fill_R8: assert property (@(posedge clk) disable iff (rst)
        $past(cap && !rsp_present && !cpu_we) && cpu_sel |->
        (cpu_rdata & size_mask(size)) == size_mask(size));

endmodule

// File: tb/tb_cfg_bridge.sv
module tb_cfg_bridge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        swap_mode = 1'b0;
    logic        cpu_req = 1'b0, cpu_sel = 1'b0, cpu_we = 1'b0;
    logic [1:0]  cpu_size = 2'b00, cpu_lane = 2'b00;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        dn_valid, dn_we;
    logic        dn_ready = 1'b0;
    logic [7:0]  dn_bus, dn_off;
    logic [4:0]  dn_dev;
    logic [2:0]  dn_fn;
    logic [3:0]  dn_be;
    logic [31:0] dn_wdata;
    logic        rsp_valid = 1'b0, rsp_present = 1'b0;
    logic [31:0] rsp_data = '0;

    int checks = 0, fails = 0;
    int n_req = 0;
    int dly = 0;
    bit done = 0;

    logic [31:0] mem [0:127];
    logic [7:0]  l_bus, l_off;
    logic [4:0]  l_dev;
    logic [2:0]  l_fn;
    logic [3:0]  l_be;
    logic [31:0] l_wdata;
    logic [31:0] rd;

    always #5 clk = ~clk;

    cfg_bridge dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit present(input logic [7:0] b, input logic [4:0] d, input logic [2:0] f);
        return b == 8'h00 && f == 3'd0 && d < 5'd2;
    endfunction

    // Reference target: claims bus 0, devices 0-1, function 0
    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 32'h1000_0000 + i * 32'h0101_0103;
        forever begin
            @(negedge clk);
            if (dn_valid) begin
                repeat (dly % 3) @(negedge clk);
                l_bus = dn_bus; l_dev = dn_dev; l_fn = dn_fn; l_off = dn_off;
                l_be = dn_be; l_wdata = dn_wdata;
                dn_ready = 1'b1;
                n_req++;
                @(negedge clk);
                dn_ready = 1'b0;
                repeat ((dly + 1) % 2) @(negedge clk);
                rsp_present = present(l_bus, l_dev, l_fn);
                rsp_data    = 32'hDEAD_0BAD;
                if (rsp_present) begin
                    if (dn_we) begin
                        for (int k = 0; k < 4; k++)
                            if (l_be[k]) mem[{l_dev[0], l_off[7:2]}][k*8 +: 8] = l_wdata[k*8 +: 8];
                    end else rsp_data = mem[{l_dev[0], l_off[7:2]}];
                end
                rsp_valid = 1'b1;
                @(negedge clk);
                rsp_valid = 1'b0;
                dly++;
            end
        end
    end

    // Every-clock monitor: no completion while a request is out (R11)
    always @(negedge clk) begin
        if (!rst && dn_valid && cpu_ready) begin
            fails++;
            $display("FAIL R11 actual=ready-during-request expected=stall");
        end
    end

    task automatic acc(input bit sel, input bit we, input logic [1:0] sz,
                       input logic [1:0] ln, input logic [31:0] wd,
                       output logic [31:0] r);
        @(negedge clk);
        cpu_sel = sel; cpu_we = we; cpu_size = sz; cpu_lane = ln; cpu_wdata = wd;
        cpu_req = 1'b1;
        #1;
        while (!cpu_ready) @(negedge clk);
        r = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    function automatic logic [31:0] exp_rd(input logic [31:0] w, input logic [1:0] sz, input logic [1:0] b);
        case (sz)
            2'b00:   return (w >> (8 * b)) & 32'hFF;
            2'b01:   return (w >> (16 * b[1])) & 32'hFFFF;
            default: return w;
        endcase
    endfunction

    initial begin
        int base;
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1
        acc(0, 0, 2'b10, 0, 0, rd);
        chk("R1", rd, 32'h0);

        // R2 and R12
        base = n_req;
        acc(0, 1, 2'b10, 0, 32'hDEAD_BEEF, rd);
        acc(0, 0, 2'b10, 0, 0, rd);
        chk("R2", rd, 32'hDEAD_BEEF);
        chk("R12", n_req - base, 0);

        // R3
        swap_mode = 1'b1;
        acc(0, 1, 2'b10, 0, 32'h0102_0304, rd);
        acc(0, 0, 2'b10, 0, 0, rd);
        chk("R3 swap read", rd, 32'h0102_0304);
        swap_mode = 1'b0;
        acc(0, 0, 2'b10, 0, 0, rd);
        chk("R3 plain read", rd, 32'h0403_0201);

        // R3 decode uses stored value: swapped write of 0x40080000 -> 0x00000840
        swap_mode = 1'b1;
        acc(0, 1, 2'b10, 0, 32'h4008_0000, rd);
        swap_mode = 1'b0;
        acc(1, 0, 2'b10, 0, 0, rd);
        chk("R3 decode off", {24'h0, l_off}, 32'h40);
        chk("R3 decode dev", {27'h0, l_dev}, 32'd1);

        // R4 R5 R6 R7: word read, high byte ignored
        acc(0, 1, 2'b10, 0, 32'hFF00_0840, rd);
        base = n_req;
        acc(1, 0, 2'b10, 0, 0, rd);
        chk("R11 one request", n_req - base, 1);
        chk("R4 fields", {l_bus, 3'b0, l_dev, 5'b0, l_fn, l_off}, {8'h00, 3'b0, 5'd1, 5'b0, 3'd0, 8'h40});
        chk("R6 word be", {28'h0, l_be}, 32'hF);
        chk("R7 word", rd, mem[{1'b1, 6'h10}]);

        // R5 R6 R7: byte read lane 3
        acc(1, 0, 2'b00, 2'd3, 0, rd);
        chk("R5 off", {24'h0, l_off}, 32'h43);
        chk("R6 byte be", {28'h0, l_be}, 32'h8);
        chk("R7 byte", rd, exp_rd(mem[{1'b1, 6'h10}], 2'b00, 2'd3));

        // R6: halfword write lane 2, then verify merge
        w = mem[{1'b1, 6'h10}];
        acc(1, 1, 2'b01, 2'd2, 32'h0000_BEEF, rd);
        chk("R6 half be", {28'h0, l_be}, 32'hC);
        chk("R6 half wdata", l_wdata, 32'hBEEF_0000);
        acc(1, 0, 2'b10, 0, 0, rd);
        chk("R7 merged", rd, {16'hBEEF, w[15:0]});

        // R6 R7: byte write lane 1, halfword read lane 1
        acc(1, 1, 2'b00, 2'd1, 32'h0000_005A, rd);
        chk("R6 byte wdata", l_wdata, 32'h0000_5A00);
        acc(1, 0, 2'b01, 2'd1, 0, rd);
        chk("R7 half", rd, {16'h0, 8'h5A, w[7:0]});

        // R5: OR merge of latch low bits with lane, offset 0xFC | 2
        acc(0, 1, 2'b10, 0, 32'h7F00_0BFC, rd);
        acc(1, 0, 2'b00, 2'd2, 0, rd);
        chk("R5 or-merge", {24'h0, l_off}, 32'hFE);
        chk("R4 fn", {29'h0, l_fn}, 32'd3);
        chk("R8 byte fill", rd, 32'h0000_00FF);

        // R8 R9: absent target on bus 3
        acc(0, 1, 2'b10, 0, 32'h0003_1000, rd);
        acc(1, 0, 2'b01, 2'd2, 0, rd);
        chk("R8 half fill", rd, 32'h0000_FFFF);
        acc(1, 0, 2'b10, 0, 0, rd);
        chk("R8 word fill", rd, 32'hFFFF_FFFF);
        acc(1, 0, 2'b11, 2'd1, 0, rd);
        chk("R9 fill", rd, 32'hFFFF_FFFF);
        chk("R9 be", {28'h0, l_be}, 32'hF);

        // R10: absent write has no side effects
        w = mem[{1'b1, 6'h10}];
        acc(1, 1, 2'b10, 0, 32'h1122_3344, rd);
        acc(0, 0, 2'b10, 0, 0, rd);
        chk("R10 latch", rd, 32'h0003_1000);
        acc(0, 1, 2'b10, 0, 32'h0000_0840, rd);
        acc(1, 0, 2'b10, 0, 0, rd);
        chk("R10 target", rd, w);

        done = 1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=complete");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule